// File: doc/BRIEF.md
# Valid-Ready Skid Buffer

A one-entry elastic stage between a valid/ready producer and a valid/ready consumer. It carries `DW` bits per word. Its upstream ready comes straight from a flop (the spare slot being empty), so a stall from the consumer does not reach the producer as a long combinational path. A word that arrives in the same cycle as a stall is parked in the spare slot. The producer is then held off until the consumer drains that slot.

Three build-time options choose the variant:
- The output stage is either a register or a combinational mux.
- A low-power option forces the data of idle outputs and of the empty slot to zero.
- A passthrough option removes all storage and wires the two handshakes straight together.

Words leave in the order they arrived, and none is lost or repeated. Reset is asynchronous and active-low.

Top module: `skid_buf`

## Requirements
- R1: While `out_valid_o` is high and `out_ready_i` is low, on the next cycle `out_valid_o` stays high and `out_data_o` is unchanged.
- R2: If a word is accepted (`in_valid_i` and `in_ready_o` both high) while `out_valid_o` is high and `out_ready_i` is low, that word is stored in the spare slot, and `in_ready_o` is low on the next cycle.
- R3: While `in_ready_o` is low, a cycle with `out_ready_i` high makes `in_ready_o` high on the next cycle.
- R4: While `rst_ni` is low, `in_ready_o` is high and `out_valid_o` is low in both buffered modes. This holds even in combinational mode with `in_valid_i` high. Reset empties the spare slot.
- R5: With `OPT_OUTREG`=1, an accepted word makes `out_valid_o` high on the next cycle. A cycle in which `in_valid_i` is low and both `in_ready_o` and `out_ready_i` are high makes `out_valid_o` low on the next cycle.
- R6: With `OPT_OUTREG`=0, the output is combinational. After any cycle with `out_ready_i` high, `out_valid_o` equals `in_valid_i`. An input word appears on `out_data_o` in the same cycle while the slot is empty.
- R7: With `OPT_LOWPOWER`=1, `out_data_o` is zero whenever `out_valid_o` is low, and the spare slot holds zero whenever it is empty (`in_ready_o` high).
- R8: With `OPT_PASSTHROUGH`=1, `out_valid_o` equals `in_valid_i`, `out_data_o` equals `in_data_i`, and `in_ready_o` equals `out_ready_i`, all in the same cycle and with no storage.
- R9: Under any pattern of upstream valid and downstream ready, delivered words come out in acceptance order, with none dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Producer has a word |
| in_ready_o | output | 1 | Buffer can take a word |
| in_data_i | input | DW | Producer word |
| out_valid_o | output | 1 | Buffer offers a word |
| out_ready_i | input | 1 | Consumer takes the word |
| out_data_o | output | DW | Offered word |

## Verification
The bound checker watches the following on every cycle:
- the stall-hold rule, the capture into the spare slot, and the return of upstream ready;
- the per-mode timing of output valid;
- the zeroing rules in low-power mode;
- the wiring in passthrough mode.

Ordering and completeness of the data stream cannot be stated as a simple property. The bench shows them instead, with a scoreboard that runs under random valid and ready patterns and finishes with a drain. The directed scenarios also show the exact cycle-by-cycle behaviour of each of the three variants.

// File: rtl/skid_pkg.sv
package skid_pkg;
  typedef enum logic [1:0] {SKID_REG, SKID_COMB, SKID_PASS} skid_mode_e;

  function automatic skid_mode_e skid_mode(bit pass, bit outreg);
    if (pass) return SKID_PASS;
    return outreg ? SKID_REG : SKID_COMB;
  endfunction
endpackage

// File: rtl/skid_slot.sv
module skid_slot #(
  parameter int DW = 8,
  parameter bit LOWPOWER = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          drain_i,
  output logic          vld_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else if (load_i) begin
      vld_o  <= 1'b1;
      data_o <= data_i;
    end else if (drain_i) begin
      vld_o <= 1'b0;
      if (LOWPOWER) data_o <= '0;
    end
  end
endmodule

// File: rtl/skid_sel.sv
module skid_sel #(
  parameter int DW = 8,
  parameter bit LOWPOWER = 1'b0
) (
  input  logic          slot_vld_i,
  input  logic [DW-1:0] slot_data_i,
  input  logic          in_vld_i,
  input  logic [DW-1:0] in_data_i,
  output logic          vld_o,
  output logic [DW-1:0] data_o
);
  // parked word always goes first
  always_comb begin
    vld_o = slot_vld_i || in_vld_i;
    if (slot_vld_i)                data_o = slot_data_i;
    else if (LOWPOWER && !in_vld_i) data_o = '0;
    else                           data_o = in_data_i;
  end
endmodule

// File: rtl/skid_out_reg.sv
module skid_out_reg #(
  parameter int DW = 8,
  parameter bit LOWPOWER = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          advance_i,
  input  logic          src_vld_i,
  input  logic [DW-1:0] src_data_i,
  output logic          vld_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else if (advance_i) begin
      vld_o  <= src_vld_i;
      data_o <= (LOWPOWER && !src_vld_i) ? '0 : src_data_i;
    end
  end
endmodule

// File: rtl/skid_buf.sv
module skid_buf #(
  parameter int DW = 8,
  parameter bit OPT_OUTREG = 1'b1,
  parameter bit OPT_LOWPOWER = 1'b0,
  parameter bit OPT_PASSTHROUGH = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o
);
  import skid_pkg::*;
  localparam skid_mode_e MODE = skid_mode(OPT_PASSTHROUGH, OPT_OUTREG);

  logic          slot_vld;
  logic [DW-1:0] slot_dat;

  if (MODE == SKID_PASS) begin : g_pass
    assign slot_vld    = 1'b0;
    assign slot_dat    = '0;
    assign in_ready_o  = out_ready_i;
    assign out_valid_o = in_valid_i;
    assign out_data_o  = in_data_i;
  end else begin : g_buf
    logic          accept;
    logic          park;
    logic          in_vld_q;
    logic          sel_vld;
    logic [DW-1:0] sel_dat;

    assign in_ready_o = !slot_vld;
    assign accept     = in_valid_i && in_ready_o;
    assign park       = accept && out_valid_o && !out_ready_i;
    assign in_vld_q   = in_valid_i && rst_ni;

    skid_slot #(.DW(DW), .LOWPOWER(OPT_LOWPOWER)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (park),
      .data_i  (in_data_i),
      .drain_i (out_ready_i),
      .vld_o   (slot_vld),
      .data_o  (slot_dat)
    );

    skid_sel #(.DW(DW), .LOWPOWER(OPT_LOWPOWER)) u_sel (
      .slot_vld_i  (slot_vld),
      .slot_data_i (slot_dat),
      .in_vld_i    (in_vld_q),
      .in_data_i   (in_data_i),
      .vld_o       (sel_vld),
      .data_o      (sel_dat)
    );

    if (MODE == SKID_REG) begin : g_reg
      skid_out_reg #(.DW(DW), .LOWPOWER(OPT_LOWPOWER)) u_out (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .advance_i  (!out_valid_o || out_ready_i),
        .src_vld_i  (sel_vld),
        .src_data_i (sel_dat),
        .vld_o      (out_valid_o),
        .data_o     (out_data_o)
      );
    end else begin : g_comb
      assign out_valid_o = sel_vld;
      assign out_data_o  = sel_dat;
    end
  end
endmodule

// File: rtl/skid_chk.sv
module skid_chk #(
  parameter int DW = 8,
  parameter bit OPT_OUTREG = 1'b1,
  parameter bit OPT_LOWPOWER = 1'b0,
  parameter bit OPT_PASSTHROUGH = 1'b0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic [DW-1:0] in_data_i,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [DW-1:0] out_data_o,
  input logic          slot_vld,
  input logic [DW-1:0] slot_dat
);
  if (!OPT_PASSTHROUGH) begin : g_buf
    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R1
    AST_SKID_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && in_ready_o && out_valid_o && !out_ready_i
      |=> !in_ready_o && slot_vld && slot_dat == $past(in_data_i)); // R2
    AST_READY_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_ready_o && out_ready_i |=> in_ready_o); // R3

    always @(posedge clk_i)
      if (!rst_ni) begin
        AST_RESET_STATE: assert (in_ready_o && !out_valid_o && !slot_vld); // R4
      end

    if (OPT_OUTREG) begin : g_reg
      AST_REG_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && in_ready_o |=> out_valid_o); // R5
      AST_REG_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i && in_ready_o && out_ready_i |=> !out_valid_o); // R5
    end else begin : g_comb
      AST_COMB_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_ready_i |=> out_valid_o == in_valid_i); // R6
    end

    if (OPT_LOWPOWER) begin : g_lp
      AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_valid_o |-> out_data_o == '0); // R7
      AST_SLOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_ready_o |-> slot_dat == '0); // R7
    end
  end else begin : g_pass
    AST_PASS_WIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o == in_valid_i && out_data_o == in_data_i
      && in_ready_o == out_ready_i && !slot_vld); // R8
  end
endmodule

bind skid_buf skid_chk #(
  .DW(DW), .OPT_OUTREG(OPT_OUTREG), .OPT_LOWPOWER(OPT_LOWPOWER),
  .OPT_PASSTHROUGH(OPT_PASSTHROUGH)
) u_chk (.*);

// File: tb/sim_skid_buf.sv
module sim_skid_buf;
  localparam int DW = 16;
  localparam int N = 3;
  localparam int RUN = 2400;

  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;  // 50 MHz

  logic          rst_ni;
  logic          ordy;
  logic          vin  [N];
  logic [DW-1:0] din  [N];
  logic          irdy [N];
  logic          ovld [N];
  logic [DW-1:0] dout [N];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // u0: registered, low power; u1: combinational, low power; u2: passthrough
  skid_buf #(.DW(DW), .OPT_OUTREG(1), .OPT_LOWPOWER(1), .OPT_PASSTHROUGH(0)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(vin[0]), .in_ready_o(irdy[0]),
    .in_data_i(din[0]), .out_valid_o(ovld[0]), .out_ready_i(ordy), .out_data_o(dout[0]));
  skid_buf #(.DW(DW), .OPT_OUTREG(0), .OPT_LOWPOWER(1), .OPT_PASSTHROUGH(0)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(vin[1]), .in_ready_o(irdy[1]),
    .in_data_i(din[1]), .out_valid_o(ovld[1]), .out_ready_i(ordy), .out_data_o(dout[1]));
  skid_buf #(.DW(DW), .OPT_OUTREG(1), .OPT_LOWPOWER(0), .OPT_PASSTHROUGH(1)) u2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(vin[2]), .in_ready_o(irdy[2]),
    .in_data_i(din[2]), .out_valid_o(ovld[2]), .out_ready_i(ordy), .out_data_o(dout[2]));

  function automatic logic [DW-1:0] word(int k, int s);
    logic [31:0] x;
    x = (32'(s) + 32'd1) * 32'h0000_9E37 ^ (32'(k) << 12);
    return x[DW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edge_in();
    @(negedge clk_i);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc [N];
    int stx [N];
    int srx [N];
    void'($urandom(32'd42));
    rst_ni = 1'b1;
    ordy = 1'b0;
    for (int k = 0; k < N; k++) begin
      vin[k] = 1'b0; din[k] = '0; acc[k] = 1'b0; stx[k] = 0; srx[k] = 0;
    end
    #1 rst_ni = 1'b0;
    vin[1] = 1'b1; din[1] = 16'h0005;
    repeat (2) edge_in();
    #1;
    chk(irdy[0] && !ovld[0], "R4 u0 reset state", {irdy[0], ovld[0]}, 2'b10);
    chk(irdy[1] && !ovld[1], "R4 u1 reset with input valid", {irdy[1], ovld[1]}, 2'b10);
    vin[1] = 1'b0;
    edge_in();
    rst_ni = 1'b1;

    // registered mode stall and skid
    edge_in(); vin[0] = 1'b1; din[0] = 16'h1111; ordy = 1'b0;
    #1 chk(irdy[0], "R5 u0 ready before fill", irdy[0], 1);
    edge_in(); din[0] = 16'h2222;
    #1 chk(ovld[0] && dout[0] == 16'h1111, "R5 u0 valid after accept", dout[0], 16'h1111);
    edge_in(); vin[0] = 1'b0; din[0] = '0;
    #1 chk(!irdy[0], "R2 u0 ready low after skid", irdy[0], 0);
    chk(ovld[0] && dout[0] == 16'h1111, "R1 u0 hold while stalled", dout[0], 16'h1111);
    edge_in(); ordy = 1'b1;
    #1 chk(dout[0] == 16'h1111, "R1 u0 hold second stall", dout[0], 16'h1111);
    edge_in();
    #1 chk(irdy[0], "R3 u0 ready returns", irdy[0], 1);
    chk(ovld[0] && dout[0] == 16'h2222, "R9 u0 parked word next", dout[0], 16'h2222);
    edge_in();
    #1 chk(!ovld[0], "R5 u0 valid drops when idle", ovld[0], 0);
    chk(dout[0] == '0, "R7 u0 idle data zero", dout[0], 0);

    // combinational mode
    edge_in(); ordy = 1'b0; vin[1] = 1'b1; din[1] = 16'h3333;
    #1 chk(ovld[1] && dout[1] == 16'h3333, "R6 u1 same-cycle output", dout[1], 16'h3333);
    chk(irdy[1], "R6 u1 ready while empty", irdy[1], 1);
    edge_in(); vin[1] = 1'b0; din[1] = '0;
    #1 chk(!irdy[1], "R2 u1 ready low after skid", irdy[1], 0);
    chk(ovld[1] && dout[1] == 16'h3333, "R1 u1 hold parked word", dout[1], 16'h3333);
    edge_in(); ordy = 1'b1;
    #1 chk(dout[1] == 16'h3333, "R1 u1 offered before drain", dout[1], 16'h3333);
    edge_in();
    #1 chk(irdy[1], "R3 u1 ready returns", irdy[1], 1);
    chk(!ovld[1], "R6 u1 valid follows input low", ovld[1], 0);
    chk(dout[1] == '0, "R7 u1 idle data zero", dout[1], 0);
    vin[1] = 1'b1; din[1] = 16'h4444;
    #1 chk(ovld[1] && dout[1] == 16'h4444, "R6 u1 valid follows input high", dout[1], 16'h4444);
    edge_in(); vin[1] = 1'b0; din[1] = '0;

    // passthrough
    ordy = 1'b0; vin[2] = 1'b1; din[2] = 16'h5555;
    #1 chk(!irdy[2] && ovld[2] && dout[2] == 16'h5555, "R8 u2 wired through",
           {irdy[2], ovld[2], dout[2]}, {2'b01, 16'h5555});
    ordy = 1'b1;
    #1 chk(irdy[2], "R8 u2 ready follows consumer", irdy[2], 1);
    edge_in(); vin[2] = 1'b0; din[2] = '0;
    repeat (3) edge_in();

    // random stream with scoreboard
    for (int c = 0; c < RUN + 100; c++) begin
      edge_in();
      ordy = (c >= RUN) ? 1'b1 : (($urandom % 10) < 7);
      for (int k = 0; k < N; k++) begin
        if (acc[k]) stx[k]++;
        if (!vin[k] || acc[k]) vin[k] = (c < RUN) && (($urandom % 10) < 6);
        din[k] = vin[k] ? word(k, stx[k]) : '0;
      end
      #1;
      for (int k = 0; k < N; k++) begin
        acc[k] = vin[k] && irdy[k];
        if (ovld[k] && ordy) begin
          chk(dout[k] == word(k, srx[k]), "R9 stream order", dout[k], word(k, srx[k]));
          srx[k]++;
        end
        if (k < 2 && !ovld[k])
          chk(dout[k] == '0, "R7 idle data zero in stream", dout[k], 0);
      end
    end
    for (int k = 0; k < N; k++) begin
      if (acc[k]) stx[k]++;
      chk(srx[k] == stx[k] && stx[k] > 100, "R9 no word lost or repeated", srx[k], stx[k]);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule